// File: doc/BRIEF.md
# Selectable ADC Conversion Clock Divider

This block derives a conversion clock for an analog-to-digital converter from the system bus clock. Software picks the divide ratio through a 3-bit field in one configuration register. The register is reached through a plain write port that carries an offset, a data word and a strobe. The current register value is always visible on a readback bus.

The ratio is one of 1, 2, 4, 8, 16, 32 or 64, or an odd divide-by-3. The block produces two views of the divided clock:

- a single-cycle enable pulse that marks the last bus cycle of each output period;
- a generated clock that is high at the start of each period.

A newly written ratio is held back until the period in progress ends, so the output never shows a shortened pulse.

The write port is a control port. It is a plain strobe with no back-pressure, and a write completes on the clock edge that samples it. No stream interface exists on this block.

Top module: `conv_clk_div`

## Requirements
- R1: The configuration register sits at offset 0x028. The ratio code is held at bits [18:16]. A write with `cfg_wr_en` high at that offset loads the code on the next rising edge. `cfg_rdata` then reads `{13'b0, code, 16'b0}`. The register changes on no other occasion.
- R2: While `rst_n` is low, `cfg_rdata` reads 0x0001_0000 (code 001, divide-by-2) and `conv_clk_en` is low.
- R3: All bits of `cfg_rdata` except [18:16] read zero, and data written to those bits is dropped. A write to any other offset leaves the register unchanged.
- R4: Codes 000, 001, 010, 011, 100, 101 and 110 select divide ratios N of 1, 2, 4, 8, 16, 32 and 64. `conv_clk_en` is high for exactly one bus cycle in every N.
- R5: Code 111 selects N = 3. `conv_clk` is high for the first bus cycle of each period and low for the other two.
- R6: For every even N, `conv_clk` is high for the first N/2 bus cycles of each period and low for the last N/2.
- R7: With N = 1, `conv_clk_en` is high on every cycle and `conv_clk` follows the bus clock.
- R8: A new code takes effect only after the enable pulse that ends the current period. A write made in the middle of a period leaves that period's length and waveform unchanged.
- R9: After `rst_n` rises, the first `conv_clk_en` pulse is seen in the bus cycle that follows the (N-1)th rising edge, with N = 2.
- R10: Every output period begins with `conv_clk` high in the cycle after an enable pulse. `conv_clk` rises only at a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset of the write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Configuration register readback |
| conv_clk_en | output | 1 | One-cycle enable at the end of each divided period |
| conv_clk | output | 1 | Generated divided clock |

## Verification
The bound checker watches several properties on every cycle:

- the reserved readback bits stay zero;
- the register changes only after a write to its own offset;
- the enable stays high while in pass-through;
- each period starts high, and the generated clock rises only after an enable pulse;
- a switch into or out of pass-through happens only on a period boundary.

Other behaviour can only be shown by the bench's scenarios, which are compared every cycle against a behavioural reference model:

- the exact pulse spacing for each of the eight codes;
- the duty cycle of each ratio;
- that a mid-period write is deferred;
- the timing of the first pulse after reset.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_DIV = 64;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  typedef logic [SEL_W-1:0] code_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W:0]   ratio_t;

  // Top code selects the odd ratio; the others are powers of two.
  function automatic ratio_t code_to_ratio(input code_t code);
    if (code == '1) return ratio_t'(3);
    return ratio_t'(1) << code;
  endfunction
endpackage

// File: rtl/div_cfg_reg.sv
`timescale 1ns/1ps
module div_cfg_reg
  import clkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h028,
  parameter int unsigned FIELD_LSB  = 16,
  parameter code_t       RESET_CODE = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output code_t             sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-SEL_W){1'b0}}, {SEL_W{1'b1}}} << FIELD_LSB;
  localparam logic [DATA_W-1:0] RESET_WORD =
    {{(DATA_W-SEL_W){1'b0}}, RESET_CODE} << FIELD_LSB;

  logic [DATA_W-1:0] word_q;
  logic              hit;

  assign hit = wr_en && (wr_addr == OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= RESET_WORD;
    else if (hit) word_q <= wr_data & FIELD_MASK;
  end

  assign rd_data = word_q;
  assign sel     = word_q[FIELD_LSB +: SEL_W];
endmodule

// File: rtl/div_period_ctr.sv
`timescale 1ns/1ps
module div_period_ctr
  import clkdiv_pkg::*;
#(
  parameter code_t RESET_CODE = 3'b001
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t sel_req,
  output logic  wrap,
  output cnt_t  nxt_cnt,
  output code_t nxt_code
);
  cnt_t   cnt_q;
  code_t  act_q;
  ratio_t act_ratio;

  assign act_ratio = code_to_ratio(act_q);
  assign wrap      = ({1'b0, cnt_q} == act_ratio - ratio_t'(1));

  // A requested code is adopted only when the running period wraps.
  always_comb begin
    if (wrap) begin
      nxt_cnt  = '0;
      nxt_code = sel_req;
    end else begin
      nxt_cnt  = cnt_q + cnt_t'(1);
      nxt_code = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RESET_CODE;
    end else begin
      cnt_q <= nxt_cnt;
      act_q <= nxt_code;
    end
  end
endmodule

// File: rtl/div_wave_gen.sv
`timescale 1ns/1ps
module div_wave_gen
  import clkdiv_pkg::*;
#(
  parameter code_t RESET_CODE = 3'b001
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cnt_t  nxt_cnt,
  input  code_t nxt_code,
  output logic  gen_q,
  output logic  pass_q
);
  ratio_t nr;
  logic   gen_d;

  assign nr = code_to_ratio(nxt_code);

  // Each period starts high; odd ratio keeps one high cycle.
  always_comb begin
    if (nr == ratio_t'(1))      gen_d = 1'b1;
    else if (nr == ratio_t'(3)) gen_d = (nxt_cnt == '0);
    else                        gen_d = ({1'b0, nxt_cnt} < (nr >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b1;
      pass_q <= (RESET_CODE == '0);
    end else begin
      gen_q  <= gen_d;
      pass_q <= (nr == ratio_t'(1));
    end
  end
endmodule

// File: rtl/conv_clk_div.sv
`timescale 1ns/1ps
module conv_clk_div
  import clkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h028,
  parameter int unsigned FIELD_LSB  = 16,
  parameter code_t       RESET_CODE = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              conv_clk_en,
  output logic              conv_clk
);
  code_t sel;
  logic  wrap;
  cnt_t  nxt_cnt;
  code_t nxt_code;
  logic  gen_q;
  logic  pass_q;

  div_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET),
    .FIELD_LSB(FIELD_LSB), .RESET_CODE(RESET_CODE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .sel(sel), .rd_data(cfg_rdata)
  );

  div_period_ctr #(.RESET_CODE(RESET_CODE)) u_ctr (
    .clk(clk), .rst_n(rst_n), .sel_req(sel), .wrap(wrap),
    .nxt_cnt(nxt_cnt), .nxt_code(nxt_code)
  );

  div_wave_gen #(.RESET_CODE(RESET_CODE)) u_wave (
    .clk(clk), .rst_n(rst_n), .nxt_cnt(nxt_cnt), .nxt_code(nxt_code),
    .gen_q(gen_q), .pass_q(pass_q)
  );

  assign conv_clk_en = wrap;
  // pass_q and gen_q both change at a rising edge with gen_q high,
  // so the select swaps while the bus clock and the divided clock agree.
  assign conv_clk = pass_q ? clk : gen_q;
endmodule

// File: rtl/conv_clk_div_checker.sv
`timescale 1ns/1ps
module conv_clk_div_checker #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h028,
  parameter int unsigned FIELD_LSB = 16,
  parameter int unsigned SEL_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              clk_en,
  input logic              gen_q,
  input logic              pass_q
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-SEL_W){1'b0}}, {SEL_W{1'b1}}} << FIELD_LSB;

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~FIELD_MASK) == '0);

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(wr_en && (wr_addr == OFFSET)));

  assert_pass_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> clk_en);

  assert_start_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> gen_q);

  assert_rise_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_q) |-> $past(clk_en));

  assert_switch_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> $past(clk_en));
endmodule

bind conv_clk_div conv_clk_div_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET), .FIELD_LSB(FIELD_LSB),
  .SEL_W(clkdiv_pkg::SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
  .rd_data(cfg_rdata), .clk_en(conv_clk_en), .gen_q(gen_q), .pass_q(pass_q)
);

// File: tb/test_conv_clk_div.sv
`timescale 1ns/1ps
module test_conv_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        conv_clk_en;
  logic        conv_clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    cmp_on = 1'b0;
  string cur_tag = "R2";

  // reference model state
  int m_sel = 1, m_ratio = 2, m_cnt = 0;

  always #10 clk = ~clk;

  conv_clk_div i_conv_clk_div (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .conv_clk_en(conv_clk_en), .conv_clk(conv_clk)
  );

  function automatic int ratio_of(input int code);
    if (code == 7) return 3;
    return 1 << code;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 1; m_ratio = 2; m_cnt = 0;
    end else begin
      if (m_cnt == m_ratio - 1) begin
        m_cnt = 0;
        m_ratio = ratio_of(m_sel);
      end else begin
        m_cnt++;
      end
      if (cfg_wr_en && cfg_addr == 12'h028) m_sel = (cfg_wdata >> 16) & 7;
    end
  end

  // compared during the high phase of the bus clock
  always @(posedge clk) begin
    #5;
    if (rst_n && cmp_on) begin
      logic exp_clk;
      if (m_ratio == 1)      exp_clk = 1'b1;
      else if (m_ratio == 3) exp_clk = (m_cnt == 0);
      else                   exp_clk = (m_cnt < m_ratio / 2);
      check(cur_tag, "conv_clk_en", {31'b0, conv_clk_en}, {31'b0, (m_cnt == m_ratio - 1)});
      check(cur_tag, "conv_clk", {31'b0, conv_clk}, {31'b0, exp_clk});
      check("R1", "cfg_rdata", cfg_rdata, 32'(m_sel) << 16);
    end
  end

  task automatic write_cfg(input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic reset_and_first_pulse();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "reset rdata", cfg_rdata, 32'h0001_0000);
    check("R2", "reset en", {31'b0, conv_clk_en}, 32'd0);
    rst_n = 1'b1;
    #1 check("R9", "en before first edge", {31'b0, conv_clk_en}, 32'd0);
    @(posedge clk); #5;
    check("R9", "first pulse", {31'b0, conv_clk_en}, 32'd1);
    @(posedge clk); #5;
    check("R9", "after first pulse", {31'b0, conv_clk_en}, 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    reset_and_first_pulse();
    cmp_on = 1'b1;

    for (int code = 0; code < 8; code++) begin
      if (code == 0)      cur_tag = "R7";
      else if (code == 7) cur_tag = "R5";
      else                cur_tag = "R4 R6 R10";
      write_cfg(12'h028, 32'(code) << 16);
      repeat (3 * ratio_of(code) + 4) @(negedge clk);
    end

    cur_tag = "R3";
    write_cfg(12'h028, 32'hFFFF_FFFF);
    check("R3", "reserved bits dropped", cfg_rdata, 32'h0007_0000);
    write_cfg(12'h02C, 32'h0000_0000);
    check("R3", "other offset ignored", cfg_rdata, 32'h0007_0000);
    repeat (8) @(negedge clk);

    cur_tag = "R8";
    write_cfg(12'h028, 32'h0000_0000);
    repeat (3) @(negedge clk);
    write_cfg(12'h028, 32'h0006_0000);
    repeat (10) @(negedge clk);
    write_cfg(12'h028, 32'h0000_0000);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #5;
      check("R8", "deferred switch", {31'b0, conv_clk_en}, 32'd0);
    end
    repeat (70) @(negedge clk);
    write_cfg(12'h028, 32'h0007_0000);
    repeat (4) @(negedge clk);
    write_cfg(12'h028, 32'h0002_0000);
    repeat (20) @(negedge clk);

    cur_tag = "R9";
    cmp_on = 1'b0;
    write_cfg(12'h028, 32'h0005_0000);
    repeat (5) @(negedge clk);
    reset_and_first_pulse();
    cmp_on = 1'b1;
    cur_tag = "R10";
    repeat (10) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule